// File: doc/BRIEF.md
# Paired Data and Byte-Mask Register File

This block holds eight register pairs. Each pair is a 256-bit data word plus a 32-bit mask, where every mask bit governs one byte of the word. A fuzzing datapath downstream needs the word and its mask together, so a single 3-bit read index returns both in the same access through a combinational read path.

Three write operations update the storage, and each has its own enable and index. A wide load puts a complete 256-bit word into one data register. The other two operations each write one half of a mask: one writes the upper 16 bits and the other writes the lower 16 bits. Setting a full mask therefore needs both. All three may fire in the same cycle, on different indices or on the same one. Every write takes effect at the rising clock edge. A synchronous active-high reset clears all pairs to zero.

Top module: `prf_pair_regfile`

## Requirements
- R1: One clock edge with `rst` high sets every data word and every mask to zero. After that edge, reading any index returns all zeros on both `rd_data` and `rd_mask`.
- R2: Within the same access, `rd_data` and `rd_mask` present the data word and the mask stored at index `rd_idx`. Mask bit i belongs to data byte i, which is bits 8i+7 down to 8i, so byte lane 0 is bits 7:0 and goes with mask bit 0.
- R3: When `ld_en` is high at a clock edge, the data register at `ld_idx` takes the full value of `ld_word`. The data registers at all other indices keep their values.
- R4: When `mh_en` is high at a clock edge, mask bits 31:16 at `mh_idx` take the value of `mh_val`. Bits 15:0 of that mask keep their value.
- R5: When `ml_en` is high at a clock edge, mask bits 15:0 at `ml_idx` take the value of `ml_val`. Bits 31:16 of that mask keep their value.
- R6: A data load, a high-half mask write and a low-half mask write may all occur in the same cycle, to different indices or to one index. Each of them takes effect at that edge.
- R7: If a read happens in the same cycle as a write to the same index, the read returns the contents from before the write. The new contents appear from the next cycle on.
- R8: When all write enables are low, the values on `ld_idx`, `ld_word`, `mh_idx`, `mh_val`, `ml_idx` and `ml_val` change no stored data and no stored mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 3 | Pair selected for reading |
| rd_data | output | 256 | Data word of the selected pair |
| rd_mask | output | 32 | Byte mask of the selected pair |
| ld_en | input | 1 | Wide data load enable |
| ld_idx | input | 3 | Pair targeted by the data load |
| ld_word | input | 256 | Word from the wide memory port |
| mh_en | input | 1 | Upper mask half write enable |
| mh_idx | input | 3 | Pair targeted by the upper half write |
| mh_val | input | 16 | Value for mask bits 31:16 |
| ml_en | input | 1 | Lower mask half write enable |
| ml_idx | input | 3 | Pair targeted by the lower half write |
| ml_val | input | 16 | Value for mask bits 15:0 |

## Verification
The hardest case to reach is a cycle in which all three write operations fire and one read observes the same index. In that cycle the read must show the old pair, and one cycle later all three updates must appear together, with no half of the mask lost. The stimulus first fills every pair with a distinct word. It then issues a triple write that spans two indices, a triple write that lands on a single index, and loads and mask writes that overlap a read of the same index, so that old and new contents can be told apart.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int DEF_NUM_PAIRS = 8;
  localparam int DEF_DATA_W    = 256;
  localparam int LANE_W        = 8;

  typedef enum logic { HALF_LO = 1'b0, HALF_HI = 1'b1 } half_e;
endpackage

// File: rtl/prf_data_bank.sv
module prf_data_bank #(
  parameter int NUM = 8,
  parameter int W   = 256,
  parameter int IW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [NUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM; i++) store[i] <= '0;
    end else if (we) begin
      store[widx] <= wdata;
    end
  end

  assign rdata = store[ridx];
endmodule

// File: rtl/prf_mask_half.sv
module prf_mask_half #(
  parameter int NUM = 8,
  parameter int HW  = 16,
  parameter int IW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [HW-1:0] wval,
  input  logic [IW-1:0] ridx,
  output logic [HW-1:0] rval
);
  logic [HW-1:0] bits_q [NUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM; i++) bits_q[i] <= '0;
    end else if (we) begin
      bits_q[widx] <= wval;
    end
  end

  assign rval = bits_q[ridx];
endmodule

// File: rtl/prf_pair_regfile.sv
module prf_pair_regfile
  import prf_pkg::*;
#(
  parameter int NUM_PAIRS = DEF_NUM_PAIRS,
  parameter int DATA_W    = DEF_DATA_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [$clog2(NUM_PAIRS)-1:0] rd_idx,
  output logic [DATA_W-1:0]            rd_data,
  output logic [DATA_W/LANE_W-1:0]     rd_mask,
  input  logic                         ld_en,
  input  logic [$clog2(NUM_PAIRS)-1:0] ld_idx,
  input  logic [DATA_W-1:0]            ld_word,
  input  logic                         mh_en,
  input  logic [$clog2(NUM_PAIRS)-1:0] mh_idx,
  input  logic [DATA_W/LANE_W/2-1:0]   mh_val,
  input  logic                         ml_en,
  input  logic [$clog2(NUM_PAIRS)-1:0] ml_idx,
  input  logic [DATA_W/LANE_W/2-1:0]   ml_val
);
  localparam int IDX_W  = $clog2(NUM_PAIRS);
  localparam int MASK_W = DATA_W / LANE_W;
  localparam int HALF_W = MASK_W / 2;

  prf_data_bank #(.NUM(NUM_PAIRS), .W(DATA_W), .IW(IDX_W)) u_data (
    .clk(clk), .rst(rst), .we(ld_en), .widx(ld_idx), .wdata(ld_word),
    .ridx(rd_idx), .rdata(rd_data)
  );

  // One bank per mask half; each half has its own write port.
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic              h_we;
    logic [IDX_W-1:0]  h_idx;
    logic [HALF_W-1:0] h_val;
    if (h == int'(HALF_HI)) begin : g_hi
      assign h_we  = mh_en;
      assign h_idx = mh_idx;
      assign h_val = mh_val;
    end else begin : g_lo
      assign h_we  = ml_en;
      assign h_idx = ml_idx;
      assign h_val = ml_val;
    end
    prf_mask_half #(.NUM(NUM_PAIRS), .HW(HALF_W), .IW(IDX_W)) u_half (
      .clk(clk), .rst(rst), .we(h_we), .widx(h_idx), .wval(h_val),
      .ridx(rd_idx), .rval(rd_mask[h*HALF_W +: HALF_W])
    );
  end
endmodule

// File: rtl/prf_pair_regfile_chk.sv
module prf_pair_regfile_chk #(
  parameter int NUM_PAIRS = 8,
  parameter int DATA_W    = 256
) (
  input logic                         clk,
  input logic                         rst,
  input logic [$clog2(NUM_PAIRS)-1:0] rd_idx,
  input logic [DATA_W-1:0]            rd_data,
  input logic [DATA_W/8-1:0]          rd_mask,
  input logic                         ld_en,
  input logic [$clog2(NUM_PAIRS)-1:0] ld_idx,
  input logic [DATA_W-1:0]            ld_word,
  input logic                         mh_en,
  input logic [$clog2(NUM_PAIRS)-1:0] mh_idx,
  input logic [DATA_W/16-1:0]         mh_val,
  input logic                         ml_en,
  input logic [$clog2(NUM_PAIRS)-1:0] ml_idx,
  input logic [DATA_W/16-1:0]         ml_val
);
  localparam int HW = DATA_W / 16;

  AST_RESET_ZEROES: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && rd_mask == '0)); // R1

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (rd_idx != $past(ld_idx) || rd_data == $past(ld_word))); // R3

  AST_HIGH_HALF_LANDS: assert property (@(posedge clk) disable iff (rst)
    mh_en |=> (rd_idx != $past(mh_idx) || rd_mask[2*HW-1:HW] == $past(mh_val))); // R4

  AST_LOW_HALF_LANDS: assert property (@(posedge clk) disable iff (rst)
    ml_en |=> (rd_idx != $past(ml_idx) || rd_mask[HW-1:0] == $past(ml_val))); // R5

  AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
    (mh_en && !ml_en && rd_idx == mh_idx) |=>
      (rd_idx != $past(rd_idx) || rd_mask[HW-1:0] == $past(rd_mask[HW-1:0]))); // R4

  AST_LOW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ml_en && !mh_en && rd_idx == ml_idx) |=>
      (rd_idx != $past(rd_idx) || rd_mask[2*HW-1:HW] == $past(rd_mask[2*HW-1:HW]))); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !mh_en && !ml_en) |=>
      (rd_idx != $past(rd_idx) || (rd_data == $past(rd_data) && rd_mask == $past(rd_mask)))); // R8
endmodule

bind prf_pair_regfile prf_pair_regfile_chk #(.NUM_PAIRS(NUM_PAIRS), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data), .rd_mask(rd_mask),
  .ld_en(ld_en), .ld_idx(ld_idx), .ld_word(ld_word),
  .mh_en(mh_en), .mh_idx(mh_idx), .mh_val(mh_val),
  .ml_en(ml_en), .ml_idx(ml_idx), .ml_val(ml_val)
);

// File: tb/test_prf_pair_regfile.sv
module test_prf_pair_regfile;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   rd_idx = '0;
  logic [255:0] rd_data;
  logic [31:0]  rd_mask;
  logic         ld_en = 1'b0;
  logic [2:0]   ld_idx = '0;
  logic [255:0] ld_word = '0;
  logic         mh_en = 1'b0;
  logic [2:0]   mh_idx = '0;
  logic [15:0]  mh_val = '0;
  logic         ml_en = 1'b0;
  logic [2:0]   ml_idx = '0;
  logic [15:0]  ml_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prf_pair_regfile i_prf_pair_regfile (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data), .rd_mask(rd_mask),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_word(ld_word),
    .mh_en(mh_en), .mh_idx(mh_idx), .mh_val(mh_val),
    .ml_en(ml_en), .ml_idx(ml_idx), .ml_val(ml_val)
  );

  typedef struct {
    string        tag;
    logic [255:0] d;
    logic [31:0]  m;
  } item_t;

  item_t        sb_q[$];
  event         push_ev;
  int           n_run = 0;
  int           n_fail = 0;
  bit           done = 1'b0;
  logic [255:0] m_data [8];
  logic [31:0]  m_mask [8];

  function automatic logic [255:0] pat(int s);
    logic [255:0] r;
    for (int k = 0; k < 8; k++)
      r[k*32 +: 32] = 32'(s) * 32'h9E3779B9 + 32'(k) * 32'h01010101 ^ 32'hC3A50000;
    return r;
  endfunction

  // Driver: drive one cycle, push expected read (pre-edge contents), update model.
  task automatic step(bit l_en, int l_i, logic [255:0] l_w,
                      bit h_en, int h_i, logic [15:0] h_v,
                      bit o_en, int o_i, logic [15:0] o_v,
                      int r_i, bit chk, string tag);
    item_t it;
    @(negedge clk);
    ld_en = l_en; ld_idx = 3'(l_i); ld_word = l_w;
    mh_en = h_en; mh_idx = 3'(h_i); mh_val = h_v;
    ml_en = o_en; ml_idx = 3'(o_i); ml_val = o_v;
    rd_idx = 3'(r_i);
    if (chk) begin
      it.tag = tag; it.d = m_data[r_i]; it.m = m_mask[r_i];
      sb_q.push_back(it);
      -> push_ev;
    end
    @(posedge clk);
    if (l_en) m_data[l_i] = l_w;
    if (h_en) m_mask[h_i][31:16] = h_v;
    if (o_en) m_mask[o_i][15:0] = o_v;
  endtask

  task automatic rd(int r_i, string tag);
    step(0, 0, '0, 0, 0, '0, 0, 0, '0, r_i, 1, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ld_en = 0; mh_en = 0; ml_en = 0;
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin m_data[i] = '0; m_mask[i] = '0; end
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Monitor: compare outputs 1 time unit after each push, well before the next edge.
  initial begin
    item_t it;
    forever begin
      @(push_ev);
      #1;
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_run++;
        if (rd_data !== it.d || rd_mask !== it.m) begin
          n_fail++;
          $display("FAIL %s idx=%0d actual data=%h mask=%h expected data=%h mask=%h",
                   it.tag, rd_idx, rd_data, rd_mask, it.d, it.m);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_data[i] = 'x; m_mask[i] = 'x; end
    do_reset();
    for (int i = 0; i < 8; i++) rd(i, "R1 reset clears");

    // R3: fill every pair with a distinct word, then read all back (R2 pairing)
    for (int i = 0; i < 8; i++) step(1, i, pat(i + 1), 0, 0, '0, 0, 0, '0, 0, 0, "");
    for (int i = 0; i < 8; i++) rd(i, "R3 load / R2 read");

    // R4, R5: halves written separately, other half retained
    step(0, 0, '0, 1, 3, 16'hA5C3, 0, 0, '0, 3, 0, "");
    rd(3, "R4 high half");
    step(0, 0, '0, 0, 0, '0, 1, 3, 16'h1234, 3, 0, "");
    rd(3, "R5 low half");
    step(0, 0, '0, 1, 3, 16'h0F0F, 0, 0, '0, 3, 0, "");
    rd(3, "R4 low kept");
    step(0, 0, '0, 0, 0, '0, 1, 3, 16'h8001, 3, 0, "");
    rd(3, "R5 high kept");
    rd(4, "R3 neighbour untouched");

    // R6: three writes in one cycle, split and same-index
    step(1, 5, pat(77), 1, 5, 16'hBEEF, 1, 2, 16'hCAFE, 0, 0, "");
    rd(5, "R6 split index a");
    rd(2, "R6 split index b");
    step(1, 6, pat(88), 1, 6, 16'h1111, 1, 6, 16'h2222, 0, 0, "");
    rd(6, "R6 same index");

    // R7: read during write to the same index returns old contents
    step(1, 1, pat(99), 0, 0, '0, 0, 0, '0, 1, 1, "R7 old data");
    rd(1, "R7 new data");
    step(0, 0, '0, 1, 0, 16'h7777, 1, 0, 16'h3C3C, 0, 1, "R7 old mask");
    rd(0, "R7 new mask");

    // R8: enables low with active-looking inputs change nothing
    step(0, 4, pat(123), 0, 4, 16'hFFFF, 0, 4, 16'hFFFF, 4, 0, "");
    step(0, 7, '1, 0, 7, 16'hDEAD, 0, 7, 16'hBEEF, 4, 0, "");
    rd(4, "R8 idle index 4");
    rd(7, "R8 idle index 7");

    // R1 again after contents are non-zero
    do_reset();
    for (int i = 0; i < 8; i++) rd(i, "R1 reset after writes");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule